// File: doc/BRIEF.md
# Eight-Channel Pin Interrupt Controller

This block watches eight already-synchronised input pins and turns each into its own interrupt line. Every channel is configured on its own as edge sensitive (rising, falling or both) or level sensitive (active high or active low). Edge events are latched until software acknowledges them. Level interrupts track the pin for as long as it stays at its active level.

Software reaches the block through a simple 32-bit register port with separate read and write strobes, a byte address and write data. Read data is combinational while the read strobe is high. Every enable register has a direct-write address, a set alias and a clear alias. Any change to an enable therefore takes a single write, with no read-modify-write sequence. In level mode the falling-enable bit is reused as the polarity select. Sticky rising and falling detect flags record every edge on every pin, whether or not the edge is enabled.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset every register reads zero and every `irq` bit is low. All channels start in edge mode with both enables clear.
- R2: The rising/level enable is written directly at 0x04, OR-set at 0x08 and cleared at 0x0C. The falling enable uses 0x10, 0x14 and 0x18 in the same way. Zero bits and bits above 7 leave the enables unchanged. Reads of either alias return the enable value.
- R3: The rising-detect register (0x1C) and the falling-detect register (0x20) set bit i on an edge of pin i, in any mode, with or without enables. Each bit is visible after the first clock edge that follows the pin change. Writing a one clears the bit, but a new edge in the same cycle keeps it set.
- R4: In edge mode, an edge that is enabled sets status bit i on the first clock edge after the pin changes. The bit then holds until a one is written to bit i at 0x24. A clear that coincides with a new enabled edge leaves the bit set, and an edge that is not enabled never sets it.
- R5: In edge mode, with both enables set, a channel responds to a rising edge and also to a falling edge.
- R6: In level mode, status bit i equals the rising/level enable ANDed with (sampled pin == falling-enable bit): 1 selects active high, 0 selects active low. The pin is sampled one clock late. Writes to 0x24 have no effect on level channels.
- R7: `irq[i]` equals status bit i, which reads at 0x24.
- R8: Register 0x00 selects the mode for each channel: 1 means level, 0 means edge. Switching a channel to level mode discards its pending edge status, and that status does not return when the channel goes back to edge mode.
- R9: Addresses 0x28 to 0x3C read as zero and ignore writes. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| pins | input | 8 | Synchronised channel inputs |
| wr_en | input | 1 | Write strobe, takes effect at the clock edge |
| rd_en | input | 1 | Read strobe; rdata is zero while it is low |
| addr | input | 6 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| irq | output | 8 | Interrupt line for each channel |

## Verification
The properties assume that `pins` changes only between clock edges and is already synchronous. They also assume that a write lasts exactly one cycle, with `wr_en` low in the cycles they treat as idle. The stimulus holds `pins` low through reset, drives pins and strobes at the falling edge, and drops `wr_en` right after each write edge. Random pin toggles and random writes to every address, mapped or unmapped, are mixed with directed sequences. These sequences cover the case where a clear and an edge land in the same cycle, polarity changes made in level mode, and a switch away from edge mode while an interrupt is pending.

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl #(
  parameter int NCH = 8,
  parameter int AW  = 6,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pins,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  output logic [NCH-1:0] irq
);

  localparam int WA = AW - 2;
  localparam logic [WA-1:0] A_MODE = WA'(0);
  localparam logic [WA-1:0] A_REN  = WA'(1);
  localparam logic [WA-1:0] A_RSET = WA'(2);
  localparam logic [WA-1:0] A_RCLR = WA'(3);
  localparam logic [WA-1:0] A_FEN  = WA'(4);
  localparam logic [WA-1:0] A_FSET = WA'(5);
  localparam logic [WA-1:0] A_FCLR = WA'(6);
  localparam logic [WA-1:0] A_RDET = WA'(7);
  localparam logic [WA-1:0] A_FDET = WA'(8);
  localparam logic [WA-1:0] A_STAT = WA'(9);

  logic [NCH-1:0] mode_q, en_r_q, en_f_q, det_r_q, det_f_q, ist_q, prev_q;
  logic [NCH-1:0] wb, rise, fall, hit, lvl, stat;
  logic [WA-1:0]  wa;
  logic           unused_bits;

  assign wa          = addr[AW-1:2];
  assign wb          = wdata[NCH-1:0];
  assign unused_bits = ^{addr[1:0], wdata[DW-1:NCH]};

  assign rise = pins & ~prev_q;
  assign fall = ~pins & prev_q;
  assign hit  = (rise & en_r_q) | (fall & en_f_q);
  assign lvl  = en_r_q & ~(prev_q ^ en_f_q);

  function automatic logic [NCH-1:0] wclr(input logic [WA-1:0] a);
    return (wr_en && wa == a) ? wb : '0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      en_r_q  <= '0;
      en_f_q  <= '0;
      det_r_q <= '0;
      det_f_q <= '0;
      ist_q   <= '0;
      prev_q  <= '0;
    end else begin
      prev_q  <= pins;
      det_r_q <= (det_r_q & ~wclr(A_RDET)) | rise;
      det_f_q <= (det_f_q & ~wclr(A_FDET)) | fall;
      ist_q   <= ~mode_q & ((ist_q & ~wclr(A_STAT)) | hit);
      if (wr_en) begin
        case (wa)
          A_MODE:  mode_q <= wb;
          A_REN:   en_r_q <= wb;
          A_RSET:  en_r_q <= en_r_q | wb;
          A_RCLR:  en_r_q <= en_r_q & ~wb;
          A_FEN:   en_f_q <= wb;
          A_FSET:  en_f_q <= en_f_q | wb;
          A_FCLR:  en_f_q <= en_f_q & ~wb;
          default: ;
        endcase
      end
    end
  end

  assign stat = (mode_q & lvl) | (~mode_q & ist_q);
  assign irq  = stat;

  logic [NCH-1:0] rsel;
  always_comb begin
    case (wa)
      A_MODE:                 rsel = mode_q;
      A_REN, A_RSET, A_RCLR:  rsel = en_r_q;
      A_FEN, A_FSET, A_FCLR:  rsel = en_f_q;
      A_RDET:                 rsel = det_r_q;
      A_FDET:                 rsel = det_f_q;
      A_STAT:                 rsel = stat;
      default:                rsel = '0;
    endcase
  end

  assign rdata = rd_en ? {{(DW-NCH){1'b0}}, rsel} : '0;

endmodule

// File: rtl/pin_irq_ctrl_chk.sv
module pin_irq_ctrl_chk #(
  parameter int NCH = 8,
  parameter int AW  = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] pins,
  input logic           wr_en,
  input logic [AW-1:0]  addr,
  input logic [NCH-1:0] wdata,
  input logic [NCH-1:0] irq,
  input logic [NCH-1:0] mode_q,
  input logic [NCH-1:0] en_r_q,
  input logic [NCH-1:0] en_f_q,
  input logic [NCH-1:0] det_r_q,
  input logic [NCH-1:0] det_f_q,
  input logic [NCH-1:0] prev_q
);
  localparam logic [AW-3:0] K_MODE = (AW-2)'(0);
  localparam logic [AW-3:0] K_RDET = (AW-2)'(7);
  localparam logic [AW-3:0] K_FDET = (AW-2)'(8);
  localparam logic [AW-3:0] K_STAT = (AW-2)'(9);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    p_level_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && mode_q[i] && en_r_q[i] && pins[i] == en_f_q[i]) |=> irq[i]);

    p_rise_det_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pins[i] && !prev_q[i]) |=> det_r_q[i]);

    p_fall_det_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!pins[i] && prev_q[i]) |=> det_f_q[i]);

    p_det_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (det_r_q[i] && !(wr_en && addr[AW-1:2] == K_RDET && wdata[i])) |=> det_r_q[i]);

    p_fdet_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (det_f_q[i] && !(wr_en && addr[AW-1:2] == K_FDET && wdata[i])) |=> det_f_q[i]);

    p_edge_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q[i] && irq[i] &&
       !(wr_en && (addr[AW-1:2] == K_MODE || (addr[AW-1:2] == K_STAT && wdata[i]))))
      |=> irq[i]);

    p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !mode_q[i] && !en_r_q[i] && !en_f_q[i] && !irq[i]) |=> !irq[i]);
  end
endmodule

bind pin_irq_ctrl pin_irq_ctrl_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pins(pins), .wr_en(wr_en), .addr(addr),
  .wdata(wdata[NCH-1:0]), .irq(irq), .mode_q(mode_q), .en_r_q(en_r_q),
  .en_f_q(en_f_q), .det_r_q(det_r_q), .det_f_q(det_f_q), .prev_q(prev_q)
);

// File: tb/tb_pin_irq_ctrl.sv
module tb_pin_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pins = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0] mm = '0, mr = '0, mf = '0, mdr = '0, mdf = '0, mist = '0, mprev = '0;

  pin_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .pins(pins), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] exp_stat();
    return (mm & mr & ~(mprev ^ mf)) | (~mm & mist);
  endfunction

  function automatic logic [31:0] exp_rd(input logic [5:0] a);
    case (a[5:2])
      4'd0:             return {24'h0, mm};
      4'd1, 4'd2, 4'd3: return {24'h0, mr};
      4'd4, 4'd5, 4'd6: return {24'h0, mf};
      4'd7:             return {24'h0, mdr};
      4'd8:             return {24'h0, mdf};
      4'd9:             return {24'h0, exp_stat()};
      default:          return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [5:0] a);
    case (a[5:2])
      4'd0:                               return "R8";
      4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6: return "R2";
      4'd7, 4'd8:                         return "R3";
      4'd9:                               return "R7";
      default:                            return "R9";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic [7:0] p, input bit w = 0,
                     input logic [5:0] a = '0, input logic [31:0] d = '0);
    logic [7:0] b, rise, fall, nm, nr, nf, ndr, ndf, nist;
    logic [3:0] wa;
    @(negedge clk);
    pins = p; wr_en = w; addr = a; wdata = d;
    b = d[7:0]; wa = a[5:2];
    rise = p & ~mprev; fall = ~p & mprev;
    nm = mm; nr = mr; nf = mf;
    if (w) begin
      case (wa)
        4'd0: nm = b;
        4'd1: nr = b;
        4'd2: nr = mr | b;
        4'd3: nr = mr & ~b;
        4'd4: nf = b;
        4'd5: nf = mf | b;
        4'd6: nf = mf & ~b;
        default: ;
      endcase
    end
    ndr  = (mdr & ~((w && wa == 4'd7) ? b : 8'h0)) | rise;
    ndf  = (mdf & ~((w && wa == 4'd8) ? b : 8'h0)) | fall;
    nist = ~mm & ((mist & ~((w && wa == 4'd9) ? b : 8'h0)) | (rise & mr) | (fall & mf));
    @(posedge clk);
    #1;
    mm = nm; mr = nr; mf = nf; mdr = ndr; mdf = ndf; mist = nist; mprev = p;
    wr_en = 1'b0;
    chk("R7 irq", {24'h0, irq}, {24'h0, exp_stat()});
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    addr = a; rd_en = 1'b1;
    #1;
    v = rdata;
    rd_en = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] p;
    logic [31:0] v;
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    for (int k = 0; k < 10; k++) rdchk("R1 reset reg", 6'(k * 4), 32'h0);
    chk("R1 irq after reset", {24'h0, irq}, 32'h0);

    // R2 enable aliases
    cyc(8'h00, 1, 6'h04, 32'h0F);
    cyc(8'h00, 1, 6'h08, 32'h30);
    rdchk("R2 set alias", 6'h04, 32'h3F);
    rdchk("R2 read set alias", 6'h08, 32'h3F);
    rdchk("R2 read clr alias", 6'h0C, 32'h3F);
    cyc(8'h00, 1, 6'h0C, 32'h05);
    rdchk("R2 clr alias", 6'h04, 32'h3A);
    cyc(8'h00, 1, 6'h14, 32'h81);
    cyc(8'h00, 1, 6'h18, 32'h01);
    rdchk("R2 falling aliases", 6'h10, 32'h80);
    cyc(8'h00, 1, 6'h08, 32'hFFFFFF00);
    rdchk("R2 upper bits no effect", 6'h04, 32'h3A);

    // R3 / R4 edges
    cyc(8'h01);
    chk("R4 disabled edge", {24'h0, irq}, 32'h0);
    rdchk("R3 detect without enable", 6'h1C, 32'h01);
    cyc(8'h03);
    chk("R4 enabled rise", {24'h0, irq}, 32'h02);
    cyc(8'h03); cyc(8'h03);
    chk("R4 status holds", {24'h0, irq}, 32'h02);
    cyc(8'h03, 1, 6'h24, 32'h02);
    chk("R4 ack clears", {24'h0, irq}, 32'h0);
    cyc(8'h0B);
    chk("R4 rise ch3", {24'h0, irq}, 32'h08);
    cyc(8'h03);
    chk("R4 disabled fall keeps", {24'h0, irq}, 32'h08);
    cyc(8'h0B, 1, 6'h24, 32'h08);
    chk("R4 edge beats clear", {24'h0, irq}, 32'h08);
    cyc(8'h03);
    cyc(8'h0B, 1, 6'h1C, 32'h08);
    rdchk("R3 edge beats clear", 6'h1C, 32'h0B);
    cyc(8'h0B, 1, 6'h1C, 32'hFF);
    rdchk("R3 write one clears", 6'h1C, 32'h0);
    rdchk("R3 falling detect", 6'h20, 32'h08);

    // R5 both edges on ch7
    cyc(8'h0B, 1, 6'h08, 32'h80);
    cyc(8'h0B, 1, 6'h24, 32'hFF);
    chk("R5 cleared", {24'h0, irq}, 32'h0);
    cyc(8'h8B);
    chk("R5 rising", {24'h0, irq}, 32'h80);
    cyc(8'h8B, 1, 6'h24, 32'h80);
    cyc(8'h0B);
    chk("R5 falling", {24'h0, irq}, 32'h80);
    cyc(8'h0B, 1, 6'h24, 32'h80);

    // R6 level mode on ch4
    cyc(8'h0B, 1, 6'h14, 32'h10);
    cyc(8'h0B, 1, 6'h00, 32'h10);
    chk("R6 high level pin low", {24'h0, irq}, 32'h0);
    cyc(8'h1B);
    chk("R6 high level pin high", {24'h0, irq}, 32'h10);
    cyc(8'h1B, 1, 6'h24, 32'h10);
    chk("R6 ack ignored", {24'h0, irq}, 32'h10);
    cyc(8'h0B);
    chk("R6 pin drops", {24'h0, irq}, 32'h0);
    cyc(8'h0B, 1, 6'h18, 32'h10);
    chk("R6 active low", {24'h0, irq}, 32'h10);
    cyc(8'h0B, 1, 6'h0C, 32'h10);
    chk("R6 disabled", {24'h0, irq}, 32'h0);

    // R8 mode switch drops pending edge
    cyc(8'h2B);
    chk("R8 pending edge", {24'h0, irq}, 32'h20);
    cyc(8'h2B, 1, 6'h00, 32'h30);
    chk("R8 level inactive", {24'h0, irq}, 32'h0);
    cyc(8'h2B, 1, 6'h00, 32'h10);
    chk("R8 edge not restored", {24'h0, irq}, 32'h0);

    // R9 unmapped
    cyc(8'h2B, 1, 6'h28, 32'hFF);
    cyc(8'h2B, 1, 6'h3F, 32'hFF);
    rdchk("R9 unmapped read", 6'h28, 32'h0);
    rdchk("R9 unmapped read hi", 6'h3C, 32'h0);
    rdchk("R9 no side effect", 6'h04, 32'hAA);
    rdchk("R9 low addr bits", 6'h07, 32'hAA);

    // random phase
    p = 8'h2B;
    for (int i = 0; i < 3000; i++) begin
      p = p ^ (8'($urandom) & 8'($urandom));
      if ($urandom % 4 == 0)
        cyc(p, 1, {4'($urandom % 16), 2'($urandom)}, $urandom);
      else
        cyc(p);
      if (i % 3 == 0) begin
        logic [5:0] a;
        a = 6'($urandom);
        rd(a, v);
        chk(tag_of(a), v, exp_rd(a));
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule